// File: doc/BRIEF.md
# Quadrature Clock Phase Calibration Controller

This block decides when the receive path re-measures the phase offset between its in-phase and quadrature clocks, runs the measurement, and owns the resulting delay setting. A measurement is a sweep of a delay-line tap index. The sweep lasts a fixed number of cycles and advances the tap by one each cycle. The tap at which an external phase comparator first reports a set level is stored as the delay value. A second comparator input, sampled on the last sweep cycle, sets a flag when the phase shift is beyond half a period.

A sweep can be started in three ways. The end of the power-up reset phase always starts one. The end of each transceive command starts one when the calibration control bit is clear. A software-driven 0-to-1 transition of that bit starts one sweep. While the control bit is set, the host may load the delay register itself. The load takes effect only once the bit has been set for at least one sweep length and no sweep is running. A start request that arrives during a sweep is dropped.

The control state machine has two states. ST_IDLE holds the tap at 0 and moves to ST_SWEEP when any start request is present. ST_SWEEP steps the tap each cycle. On the cycle holding the last tap it commits the result and returns to ST_IDLE.

Top module: `qclk_cal_ctrl`

## Requirements
- R1: After reset, busy is 0, tap_idx is 0, dly_val is 0 and over180 is 0.
- R2: A one-cycle pulse on init_done while idle starts a sweep whatever the level of cal_ctrl; busy is 1 from the cycle after the pulse.
- R3: A pulse on xcv_end while idle starts a sweep when cal_ctrl is 0 and is ignored (busy stays 0, dly_val unchanged) when cal_ctrl is 1.
- R4: A 0-to-1 change of cal_ctrl starts exactly one sweep; holding cal_ctrl at 1 starts no further sweep. The level cal_ctrl has at reset release does not count as a change.
- R5: A sweep keeps busy at 1 for exactly CAL_LEN (default 65) cycles, with tap_idx equal to 0, 1, … CAL_LEN-1 in successive cycles; tap_idx is 0 while idle.
- R6: When a sweep ends, dly_val takes the first tap_idx value during which phase_cmp was 1, or CAL_LEN-1 if phase_cmp was never 1; the new value is visible in the first idle cycle.
- R7: When a sweep ends, over180 takes the value that wrap_cmp had in the last sweep cycle.
- R8: A host_wr pulse loads host_wdata into dly_val on the next cycle if cal_ctrl has been 1 for at least CAL_LEN cycles and no sweep is running.
- R9: A host_wr pulse while cal_ctrl is 0, or during a sweep, leaves dly_val unchanged.
- R10: A start request of any kind during a sweep is ignored; the sweep keeps its length and tap sequence and no second sweep follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_done | input | 1 | One-cycle pulse at the end of the reset phase |
| xcv_end | input | 1 | One-cycle pulse at the end of a transceive command |
| cal_ctrl | input | 1 | Calibration control bit: 0 auto after transceive, 1 suppress; rising edge forces one sweep |
| host_wr | input | 1 | Host write strobe for the delay register |
| host_wdata | input | TAP_W | Host write data for the delay register |
| phase_cmp | input | 1 | Phase comparator output for the present tap |
| wrap_cmp | input | 1 | Comparator output that is 1 when the phase shift exceeds 180 degrees |
| busy | output | 1 | High for the whole sweep window |
| tap_idx | output | TAP_W | Tap index driven to the delay line |
| dly_val | output | TAP_W | Delay register value |
| over180 | output | 1 | Phase shift above 180 degrees flag |

## Verification
The assertions take init_done, xcv_end and host_wr to be single-cycle pulses that are synchronous to clk. They take phase_cmp to depend only on the present tap index, and they take cal_ctrl to change no more often than a software register write would. The bench drives every input on the falling clock edge. It produces phase_cmp as a threshold compare on the tap_idx output, so the comparator is monotonic in the tap. It issues each strobe for exactly one cycle. It places the deliberate mid-sweep start requests and host writes inside a running window, so it never has to rely on the result of two events landing on the same edge.

// File: rtl/qcal_pkg.sv
package qcal_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_SWEEP = 1'b1
    } qcal_state_e;
endpackage

// File: rtl/qcal_trig.sv
module qcal_trig #(
    parameter int CAL_LEN = 65,
    localparam int CNT_W = $clog2(CAL_LEN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cal_ctrl,
    input  logic init_done,
    input  logic xcv_end,
    input  logic busy,
    output logic start,
    output logic wr_ok
);
    localparam logic [CNT_W-1:0] SETTLE = CNT_W'(CAL_LEN);

    logic             ctrl_prev_q;
    logic [CNT_W-1:0] settle_q;
    logic             ctrl_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_prev_q <= 1'b1;
            settle_q    <= '0;
        end else begin
            ctrl_prev_q <= cal_ctrl;
            if (!cal_ctrl)
                settle_q <= '0;
            else if (settle_q != SETTLE)
                settle_q <= settle_q + 1'b1;
        end
    end

    always_comb begin
        ctrl_rise = cal_ctrl && !ctrl_prev_q;
        start     = init_done || (xcv_end && !cal_ctrl) || ctrl_rise;
        wr_ok     = cal_ctrl && (settle_q == SETTLE) && !busy;
    end

    // R8: a write may only be granted once the settle counter has saturated
    assert_settle_before_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |-> (cal_ctrl && $past(cal_ctrl)));
endmodule

// File: rtl/qcal_sweep.sv
module qcal_sweep
    import qcal_pkg::*;
#(
    parameter int CAL_LEN = 65,
    parameter int TAP_W   = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             phase_cmp,
    input  logic             wrap_cmp,
    output logic             busy,
    output logic [TAP_W-1:0] tap_idx,
    output logic             done,
    output logic [TAP_W-1:0] result,
    output logic             wrap_res
);
    localparam logic [TAP_W-1:0] LAST = TAP_W'(CAL_LEN - 1);

    qcal_state_e      state_q, state_d;
    logic [TAP_W-1:0] tap_q;
    logic [TAP_W-1:0] cap_q;
    logic             found_q;
    logic             at_last;

    assign at_last = (tap_q == LAST);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)   state_d = ST_SWEEP;
            ST_SWEEP: if (at_last) state_d = ST_IDLE;
            default:               state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tap_q   <= '0;
            cap_q   <= '0;
            found_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    tap_q   <= '0;
                    found_q <= 1'b0;
                end
                ST_SWEEP: begin
                    if (!found_q && phase_cmp) begin
                        found_q <= 1'b1;
                        cap_q   <= tap_q;
                    end
                    tap_q <= at_last ? '0 : tap_q + 1'b1;
                end
                default: tap_q <= '0;
            endcase
        end
    end

    always_comb begin
        busy     = (state_q == ST_SWEEP);
        tap_idx  = tap_q;
        done     = busy && at_last;
        result   = found_q ? cap_q : LAST;
        wrap_res = wrap_cmp;
    end

    assert_window_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && tap_idx == LAST) |=> !busy);
    assert_idle_tap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tap_idx == '0);
    assert_retrig_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && tap_idx != LAST) |=> (busy && tap_idx == $past(tap_idx) + 1'b1));
    assert_sweep_starts_at_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> tap_idx == '0);
endmodule

// File: rtl/qcal_dly_reg.sv
module qcal_dly_reg #(
    parameter int TAP_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done,
    input  logic [TAP_W-1:0] result,
    input  logic             wrap_res,
    input  logic             host_wr,
    input  logic [TAP_W-1:0] host_wdata,
    input  logic             wr_ok,
    output logic [TAP_W-1:0] dly_val,
    output logic             over180
);
    logic [TAP_W-1:0] dly_q;
    logic             over_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dly_q  <= '0;
            over_q <= 1'b0;
        end else if (done) begin
            dly_q  <= result;
            over_q <= wrap_res;
        end else if (host_wr && wr_ok) begin
            dly_q <= host_wdata;
        end
    end

    assign dly_val = dly_q;
    assign over180 = over_q;

    assert_host_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && wr_ok && !done) |=> dly_val == $past(host_wdata));
    assert_flag_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(over180));
endmodule

// File: rtl/qclk_cal_ctrl.sv
module qclk_cal_ctrl #(
    parameter int CAL_LEN = 65,
    localparam int TAP_W = $clog2(CAL_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_done,
    input  logic             xcv_end,
    input  logic             cal_ctrl,
    input  logic             host_wr,
    input  logic [TAP_W-1:0] host_wdata,
    input  logic             phase_cmp,
    input  logic             wrap_cmp,
    output logic             busy,
    output logic [TAP_W-1:0] tap_idx,
    output logic [TAP_W-1:0] dly_val,
    output logic             over180
);
    logic             start;
    logic             wr_ok;
    logic             done;
    logic [TAP_W-1:0] result;
    logic             wrap_res;

    qcal_trig #(.CAL_LEN(CAL_LEN)) u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .cal_ctrl  (cal_ctrl),
        .init_done (init_done),
        .xcv_end   (xcv_end),
        .busy      (busy),
        .start     (start),
        .wr_ok     (wr_ok)
    );

    qcal_sweep #(.CAL_LEN(CAL_LEN), .TAP_W(TAP_W)) u_sweep (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .phase_cmp (phase_cmp),
        .wrap_cmp  (wrap_cmp),
        .busy      (busy),
        .tap_idx   (tap_idx),
        .done      (done),
        .result    (result),
        .wrap_res  (wrap_res)
    );

    qcal_dly_reg #(.TAP_W(TAP_W)) u_dly (
        .clk        (clk),
        .rst_n      (rst_n),
        .done       (done),
        .result     (result),
        .wrap_res   (wrap_res),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .wr_ok      (wr_ok),
        .dly_val    (dly_val),
        .over180    (over180)
    );

    assert_init_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done && !busy) |=> busy);
    assert_xcv_auto_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (xcv_end && !cal_ctrl && !busy) |=> busy);
    assert_no_write_when_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cal_ctrl && !busy) |=> $stable(dly_val));
    assert_busy_write_dropped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(dly_val));
endmodule

// File: tb/qclk_cal_ctrl_tb.sv
module qclk_cal_ctrl_tb;
    localparam int CAL_LEN = 65;
    localparam int TAP_W   = $clog2(CAL_LEN);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             init_done = 1'b0;
    logic             xcv_end = 1'b0;
    logic             cal_ctrl = 1'b0;
    logic             host_wr = 1'b0;
    logic [TAP_W-1:0] host_wdata = '0;
    logic             phase_cmp;
    logic             wrap_cmp = 1'b0;
    logic             busy;
    logic [TAP_W-1:0] tap_idx;
    logic [TAP_W-1:0] dly_val;
    logic             over180;

    int thr = 1000;
    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    assign phase_cmp = (int'(tap_idx) >= thr);

    qclk_cal_ctrl #(.CAL_LEN(CAL_LEN)) u_dut (
        .clk(clk), .rst_n(rst_n), .init_done(init_done), .xcv_end(xcv_end),
        .cal_ctrl(cal_ctrl), .host_wr(host_wr), .host_wdata(host_wdata),
        .phase_cmp(phase_cmp), .wrap_cmp(wrap_cmp), .busy(busy),
        .tap_idx(tap_idx), .dly_val(dly_val), .over180(over180)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_init();
        init_done = 1'b1; @(negedge clk); init_done = 1'b0;
    endtask

    task automatic pulse_xcv();
        xcv_end = 1'b1; @(negedge clk); xcv_end = 1'b0;
    endtask

    task automatic host_write(input int v);
        host_wdata = TAP_W'(v); host_wr = 1'b1; @(negedge clk); host_wr = 1'b0;
    endtask

    // Called on a negedge where busy should already be 1; counts the window.
    task automatic run_window(input int poke_at, input bit poke_wr, output int len, output bit tap_ok);
        len = 0; tap_ok = 1'b1;
        while (busy && len < 200) begin
            if (int'(tap_idx) != len) tap_ok = 1'b0;
            if (poke_at > 0 && len == poke_at) begin
                if (poke_wr) begin host_wdata = 7'd50; host_wr = 1'b1; end
                else begin xcv_end = 1'b1; init_done = 1'b1; end
            end
            @(negedge clk);
            xcv_end = 1'b0; init_done = 1'b0; host_wr = 1'b0;
            len++;
        end
    endtask

    task automatic idle_for(input int cycles, output bit stayed);
        stayed = 1'b1;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (busy) stayed = 1'b0;
        end
    endtask

    task automatic t_reset();
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(tap_idx == '0, "R1 tap_idx", tap_idx, 0);
        chk(dly_val == '0, "R1 dly_val", dly_val, 0);
        chk(over180 == 1'b0, "R1 over180", over180, 0);
    endtask

    task automatic t_post_reset();
        int len; bit ok;
        thr = 20; wrap_cmp = 1'b1;
        pulse_init();
        chk(busy == 1'b1, "R2 busy after init_done", busy, 1);
        run_window(0, 1'b0, len, ok);
        chk(len == CAL_LEN, "R5 window length", len, CAL_LEN);
        chk(ok, "R5 tap sequence", ok, 1);
        chk(tap_idx == '0, "R5 tap idle", tap_idx, 0);
        chk(dly_val == 7'd20, "R6 first set tap", dly_val, 20);
        chk(over180 == 1'b1, "R7 flag set", over180, 1);
    endtask

    task automatic t_xcv_retrig();
        int len; bit ok, stayed;
        thr = 1000; wrap_cmp = 1'b0;
        pulse_xcv();
        chk(busy == 1'b1, "R3 xcv_end with ctrl 0", busy, 1);
        run_window(10, 1'b0, len, ok);
        chk(len == CAL_LEN, "R10 length with retrigger", len, CAL_LEN);
        chk(ok, "R10 tap sequence with retrigger", ok, 1);
        idle_for(5, stayed);
        chk(stayed, "R10 no follow-on sweep", stayed, 1);
        chk(dly_val == 7'(CAL_LEN - 1), "R6 no set tap", dly_val, CAL_LEN - 1);
        chk(over180 == 1'b0, "R7 flag clear", over180, 0);
    endtask

    task automatic t_ctrl_rise();
        int len; bit ok, stayed;
        thr = 5;
        cal_ctrl = 1'b1; @(negedge clk);
        chk(busy == 1'b1, "R4 rise starts sweep", busy, 1);
        run_window(0, 1'b0, len, ok);
        chk(len == CAL_LEN, "R4 one window", len, CAL_LEN);
        chk(dly_val == 7'd5, "R6 after rise", dly_val, 5);
        idle_for(10, stayed);
        chk(stayed, "R4 held level no repeat", stayed, 1);
        thr = 0;
        pulse_xcv();
        idle_for(3, stayed);
        chk(stayed && busy == 1'b0, "R3 xcv_end ignored with ctrl 1", busy, 0);
        chk(dly_val == 7'd5, "R3 dly unchanged", dly_val, 5);
    endtask

    task automatic t_host_write();
        int len; bit ok;
        host_write(33);
        chk(dly_val == 7'd33, "R8 host load", dly_val, 33);
        cal_ctrl = 1'b0; @(negedge clk);
        host_write(44);
        chk(dly_val == 7'd33, "R9 write with ctrl 0", dly_val, 33);
        thr = 7;
        cal_ctrl = 1'b1; @(negedge clk);
        run_window(20, 1'b1, len, ok);
        chk(dly_val == 7'd7, "R9 write during sweep dropped", dly_val, 7);
        host_write(61);
        chk(dly_val == 7'd61, "R8 load after settle", dly_val, 61);
    endtask

    task automatic t_init_ctrl_set();
        int len; bit ok;
        thr = 12;
        pulse_init();
        chk(busy == 1'b1, "R2 init_done with ctrl 1", busy, 1);
        run_window(0, 1'b0, len, ok);
        chk(dly_val == 7'd12, "R2 result with ctrl 1", dly_val, 12);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_post_reset();
        t_xcv_retrig();
        t_ctrl_rise();
        t_host_write();
        t_init_ctrl_set();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule